// File: doc/BRIEF.md
# Beacon Superframe Interval Timer

This block paces a beacon-enabled low-rate wireless MAC. It counts symbol-tick strobes and marks out two nested spans. The first is the beacon interval, which runs from one beacon start to the next. The second is the active part of the superframe, which opens at each beacon start. Both spans are a fixed base of 960 symbols scaled by a power of two. One order byte supplies the two exponents: the upper nibble holds the interval exponent and the lower nibble holds the active-span exponent.

Software writes the order byte through a one-cycle write strobe. A legal value is held as pending and takes effect at the next interval boundary. An illegal value stops the timer and raises a sticky error. The outputs are a one-cycle beacon-start pulse, an active flag and an inactive flag. The MAC uses them to schedule beacon transmission and to power down during the inactive span.

Top module: `bsf_superframe_timer`

## Requirements
- R1: After reset all four outputs are low, and they stay low while no order byte has been written.
- R2: The order byte carries the interval exponent BO in bits 7:4 and the active exponent SO in bits 3:0. When the timer runs, consecutive beacon starts are 960·2^BO symbol ticks apart.
- R3: In each interval, sf_active is high for the first 960·2^SO ticks, counting from the beacon-start cycle. sf_inactive is high for the rest of the interval.
- R4: When BO equals SO, sf_inactive never asserts.
- R5: beacon_start is high for exactly one clock cycle, and that cycle lies inside the active span.
- R6: The count advances only on clock edges where sym_tick is high. With no ticks, all outputs hold their values and no beacon starts.
- R7: A write with SO greater than BO, or with BO above 14, sets order_err. From the next cycle all timing outputs are low, and the timer stays idle.
- R8: order_err stays set across further illegal writes. A legal write clears it. The first beacon start then appears on the second clock edge after the write edge, provided sym_tick is high there.
- R9: A legal write made while the timer runs leaves the current interval length unchanged. The new orders apply from the next beacon start.
- R10: While timer_en is low all timing outputs are low. When timer_en goes high again, a beacon start occurs on the first ticked edge.
- R11: sf_active and sf_inactive are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_tick | input | 1 | One-cycle strobe, one per symbol period |
| timer_en | input | 1 | Runs the timer when high |
| order_wr | input | 1 | Write strobe for order_in |
| order_in | input | 8 | Order byte: BO in [7:4], SO in [3:0] |
| beacon_start | output | 1 | One-cycle pulse at each interval start |
| sf_active | output | 1 | High during the active span |
| sf_inactive | output | 1 | High during the inactive span |
| order_err | output | 1 | Sticky flag for an illegal order byte |

## Verification
Interval and active lengths are measured with equal orders, with unequal orders (a half split and a one-in-eight split) and with ticks every third clock. These runs separate a shift by BO from a shift by SO and separate tick counting from clock counting. A gap in the tick stream tests the hold behaviour. A write made mid-interval shows whether a new value is taken early or at the boundary. Illegal writes of both kinds, followed by a legal one, check the sticky flag and the exact start cycle. A disable and re-enable checks the enable path.

// File: rtl/bsf_pkg.sv
// Shared types for the beacon superframe timer.
// Assumes a byte-wide order register split into two equal nibbles.
package bsf_pkg;
    localparam int ORD_W = 4;
    typedef logic [ORD_W-1:0] ord_t;
    // Upper nibble: interval exponent; lower nibble: active exponent.
    typedef struct packed {
        ord_t bcn_ord;
        ord_t act_ord;
    } order_cfg_t;
endpackage

// File: rtl/bsf_cfg_ctrl.sv
// Order register control: checks each written order byte, holds a legal
// value as pending until the next interval boundary, and keeps a sticky
// error for an illegal one. Assumes restart pulses only while run_ok is high.
module bsf_cfg_ctrl
    import bsf_pkg::*;
#(
    parameter int MAX_ORDER = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timer_en,
    input  logic       order_wr,
    input  order_cfg_t order_in,
    input  logic       restart,
    output order_cfg_t cur_cfg,
    output logic       run_ok,
    output logic       order_err
);
    order_cfg_t cur_q, pend_q;
    logic       cur_ok_q, pend_ok_q, err_q;
    logic       wr_legal;

    // Legality: interval exponent in range, active exponent not above it.
    assign wr_legal = (order_in.bcn_ord <= ord_t'(MAX_ORDER)) &&
                      (order_in.act_ord <= order_in.bcn_ord);

    // Register update: a write wins over taking the pending value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            pend_q    <= '0;
            cur_ok_q  <= 1'b0;
            pend_ok_q <= 1'b0;
            err_q     <= 1'b0;
        end else if (order_wr) begin
            if (wr_legal) begin
                pend_q    <= order_in;
                pend_ok_q <= 1'b1;
                err_q     <= 1'b0;
            end else begin
                pend_ok_q <= 1'b0;
                cur_ok_q  <= 1'b0;
                err_q     <= 1'b1;
            end
        end else if (restart && pend_ok_q) begin
            cur_q     <= pend_q;
            cur_ok_q  <= 1'b1;
            pend_ok_q <= 1'b0;
        end
    end

    // Run permission: enabled, no error, some legal setting, no bad write now.
    always_comb begin
        run_ok = timer_en && !err_q && (cur_ok_q || pend_ok_q) &&
                 !(order_wr && !wr_legal);
    end

    assign cur_cfg   = cur_q;
    assign order_err = err_q;
endmodule

// File: rtl/bsf_sym_counter.sv
// Symbol counter: counts ticks inside an interval, restarts at zero on the
// last symbol or when the timer first starts, and registers the beacon pulse.
// Assumes at_last is computed from the setting in force for this interval.
module bsf_sym_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_tick,
    input  logic             run_ok,
    input  logic             at_last,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             restart,
    output logic             beacon
);
    logic [CNT_W-1:0] cnt_q;
    logic             running_q, bcn_q;

    // Boundary: the first tick after start, or the tick on the last symbol.
    assign restart = run_ok && sym_tick && (!running_q || at_last);

    // Count state: cleared while stopped, stepped on ticks while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_ok) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            bcn_q     <= 1'b0;
        end else begin
            bcn_q <= restart;
            if (restart) begin
                cnt_q     <= '0;
                running_q <= 1'b1;
            end else if (sym_tick) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cnt     = cnt_q;
    assign running = running_q;
    assign beacon  = bcn_q;
endmodule

// File: rtl/bsf_phase_decode.sv
// Phase decode: turns the symbol count and the current orders into the
// last-symbol marker and the active/inactive flags.
// Assumes BASE_SYMS << MAX_ORDER fits in CNT_W bits.
module bsf_phase_decode
    import bsf_pkg::*;
#(
    parameter int BASE_SYMS = 960,
    parameter int CNT_W     = 24
) (
    input  order_cfg_t       cur_cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic             running,
    output logic             at_last,
    output logic             active,
    output logic             inactive
);
    logic [CNT_W-1:0] bi_len, sd_len;

    // Span lengths: the base scaled by each exponent.
    always_comb begin
        bi_len = CNT_W'(BASE_SYMS) << cur_cfg.bcn_ord;
        sd_len = CNT_W'(BASE_SYMS) << cur_cfg.act_ord;
    end

    // Flags: compare the count against the two span ends.
    always_comb begin
        at_last  = (cnt == bi_len - CNT_W'(1));
        active   = running && (cnt < sd_len);
        inactive = running && !(cnt < sd_len);
    end
endmodule

// File: rtl/bsf_superframe_timer.sv
// Top of the beacon superframe timer: wires order control, symbol counter
// and phase decode. Assumes sym_tick is a single-cycle strobe.
module bsf_superframe_timer
    import bsf_pkg::*;
#(
    parameter int BASE_SYMS = 960,
    parameter int MAX_ORDER = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sym_tick,
    input  logic               timer_en,
    input  logic               order_wr,
    input  logic [2*ORD_W-1:0] order_in,
    output logic               beacon_start,
    output logic               sf_active,
    output logic               sf_inactive,
    output logic               order_err
);
    localparam int CNT_W = $clog2(BASE_SYMS + 1) + MAX_ORDER;

    order_cfg_t       cur_cfg;
    logic             run_ok, restart, at_last, running;
    logic [CNT_W-1:0] cnt;

    bsf_cfg_ctrl #(.MAX_ORDER(MAX_ORDER)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_en  (timer_en),
        .order_wr  (order_wr),
        .order_in  (order_cfg_t'(order_in)),
        .restart   (restart),
        .cur_cfg   (cur_cfg),
        .run_ok    (run_ok),
        .order_err (order_err)
    );

    bsf_sym_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_tick (sym_tick),
        .run_ok   (run_ok),
        .at_last  (at_last),
        .cnt      (cnt),
        .running  (running),
        .restart  (restart),
        .beacon   (beacon_start)
    );

    bsf_phase_decode #(.BASE_SYMS(BASE_SYMS), .CNT_W(CNT_W)) u_dec (
        .cur_cfg  (cur_cfg),
        .cnt      (cnt),
        .running  (running),
        .at_last  (at_last),
        .active   (sf_active),
        .inactive (sf_inactive)
    );
endmodule

// File: rtl/bsf_superframe_timer_chk.sv
// Port-level checker for the beacon superframe timer, bound to the top.
module bsf_superframe_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic sym_tick,
    input logic timer_en,
    input logic order_wr,
    input logic beacon_start,
    input logic sf_active,
    input logic sf_inactive,
    input logic order_err
);
    p_beacon_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beacon_start |=> !beacon_start);

    p_beacon_in_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        beacon_start |-> sf_active);

    p_flags_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sf_active && sf_inactive));

    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> (!sf_active && !sf_inactive && !beacon_start));

    p_disable_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_en |=> (!sf_active && !sf_inactive && !beacon_start));

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_tick && timer_en && !order_wr) |=>
            ($stable(sf_active) && $stable(sf_inactive) && !beacon_start));
endmodule

bind bsf_superframe_timer bsf_superframe_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_tick     (sym_tick),
    .timer_en     (timer_en),
    .order_wr     (order_wr),
    .beacon_start (beacon_start),
    .sf_active    (sf_active),
    .sf_inactive  (sf_inactive),
    .order_err    (order_err)
);

// File: tb/bsf_superframe_timer_tb.sv
module bsf_superframe_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 960;
    localparam int LIMIT      = 40000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_tick = 1'b0;
    logic       timer_en = 1'b0;
    logic       order_wr = 1'b0;
    logic [7:0] order_in = 8'h00;
    logic       beacon_start, sf_active, sf_inactive, order_err;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;

    bsf_superframe_timer u_dut (
        .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .timer_en(timer_en),
        .order_wr(order_wr), .order_in(order_in), .beacon_start(beacon_start),
        .sf_active(sf_active), .sf_inactive(sf_inactive), .order_err(order_err)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Tick source: one strobe every tick_div clocks, none when tick_div is 0.
    initial begin
        int phase = 0;
        forever begin
            @(negedge clk);
            if (tick_div == 0) sym_tick = 1'b0;
            else begin
                phase = phase + 1;
                if (phase >= tick_div) phase = 0;
                sym_tick = (phase == 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_order(input int bo, input int so);
        order_in = 8'((bo << 4) | so);
        order_wr = 1'b1;
        @(negedge clk);
        order_wr = 1'b0;
    endtask

    task automatic wait_beacon(output int waited);
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!beacon_start && waited < LIMIT);
    endtask

    // Interval from one beacon to the next, with active/inactive cycle counts.
    task automatic measure(output int per, output int act, output int inact);
        int w;
        per = 0; act = 0; inact = 0;
        wait_beacon(w);
        do begin
            if (sf_active) act++;
            if (sf_inactive) inact++;
            per++;
            @(negedge clk);
        end while (!beacon_start && per < LIMIT);
    endtask

    // Count cycles over n where any timing output is high.
    task automatic quiet_cycles(input int n, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (beacon_start || sf_active || sf_inactive) bad++;
        end
    endtask

    task automatic t_reset;
        int bad;
        chk("R1 beacon", beacon_start, 0);
        chk("R1 active", sf_active, 0);
        chk("R1 inactive", sf_inactive, 0);
        chk("R1 err", order_err, 0);
        quiet_cycles(200, bad);
        chk("R1 idle without order", bad, 0);
    endtask

    task automatic t_equal;
        int p, a, i;
        write_order(0, 0);
        chk("R8 no beacon on first edge", beacon_start, 0);
        @(negedge clk);
        chk("R8 beacon on second edge", beacon_start, 1);
        measure(p, a, i);
        chk("R2 period bo0", p, BASE);
        chk("R3 active so0", a, BASE);
        chk("R4 inactive bo=so=0", i, 0);
        write_order(2, 2);
        measure(p, a, i);
        chk("R2 period bo2", p, BASE * 4);
        chk("R4 inactive bo=so=2", i, 0);
    endtask

    task automatic t_unequal;
        int p, a, i;
        write_order(2, 1);
        measure(p, a, i);
        chk("R2 period bo2", p, BASE * 4);
        chk("R3 active so1", a, BASE * 2);
        chk("R3 inactive bo2 so1", i, BASE * 2);
        write_order(3, 0);
        measure(p, a, i);
        chk("R2 period bo3", p, BASE * 8);
        chk("R3 active so0", a, BASE);
        chk("R3 inactive bo3 so0", i, BASE * 7);
    endtask

    task automatic t_tick_div;
        int p, a, i;
        tick_div = 3;
        write_order(1, 0);
        measure(p, a, i);
        chk("R6 period with ticks every 3rd clock", p, BASE * 2 * 3);
        chk("R6 active with ticks every 3rd clock", a, BASE * 3);
        tick_div = 1;
        measure(p, a, i);
        chk("R2 period bo1", p, BASE * 2);
    endtask

    task automatic t_hold;
        int w, bad, p, a, i;
        wait_beacon(w);
        repeat (1200) @(negedge clk);
        tick_div = 0;
        repeat (3) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!sf_inactive || sf_active || beacon_start) bad++;
        end
        chk("R6 hold with no ticks", bad, 0);
        tick_div = 1;
        measure(p, a, i);
        chk("R6 period after tick gap", p, BASE * 2);
    endtask

    task automatic t_midchange;
        int w, p, a, i;
        wait_beacon(w);
        repeat (100) @(negedge clk);
        write_order(0, 0);
        wait_beacon(w);
        chk("R9 current interval keeps old length", w + 101, BASE * 2);
        measure(p, a, i);
        chk("R9 new length after boundary", p, BASE);
    endtask

    task automatic t_invalid;
        int bad, p, a, i;
        write_order(1, 2);
        chk("R7 err on so>bo", order_err, 1);
        chk("R7 active low", sf_active, 0);
        chk("R7 inactive low", sf_inactive, 0);
        quiet_cycles(2000, bad);
        chk("R7 idle after bad write", bad, 0);
        write_order(15, 3);
        chk("R8 err sticky on bo=15", order_err, 1);
        quiet_cycles(100, bad);
        chk("R7 idle with bo=15", bad, 0);
        write_order(1, 1);
        chk("R8 err cleared by legal write", order_err, 0);
        chk("R8 no beacon on first edge", beacon_start, 0);
        @(negedge clk);
        chk("R8 beacon on second edge", beacon_start, 1);
        measure(p, a, i);
        chk("R8 period after recovery", p, BASE * 2);
        chk("R4 inactive bo=so=1", i, 0);
    endtask

    task automatic t_disable;
        int bad, p, a, i, w;
        wait_beacon(w);
        repeat (50) @(negedge clk);
        timer_en = 1'b0;
        @(negedge clk);
        quiet_cycles(500, bad);
        chk("R10 outputs low while disabled", bad, 0);
        timer_en = 1'b1;
        @(negedge clk);
        chk("R10 beacon on re-enable", beacon_start, 1);
        chk("R5 beacon within active", sf_active, 1);
        @(negedge clk);
        chk("R5 beacon lasts one cycle", beacon_start, 0);
        measure(p, a, i);
        chk("R10 period after re-enable", p, BASE * 2);
        chk("R11 active and inactive cover interval once", a + i, p);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        timer_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_equal();
        t_unequal();
        t_tick_div();
        t_hold();
        t_midchange();
        t_invalid();
        t_disable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule